// File: doc/BRIEF.md
# Matrix Keypad Scan Decoder

This block reads a 16-key matrix keypad laid out as four rows by four columns. It pulls one column line low at a time and lets the others float high on their pull-ups. The low column walks around a ring at a slow, divided rate. On each scan step the four row lines are sampled, and any row pulled low marks a key in the column that is being driven. The active-low row and column patterns are inverted into one-hot nibbles and joined into an 8-bit code, with the row in the upper nibble. A fully computed 256-entry table turns that code into a hex digit, or into a "no key" result.

The last valid digit is held on the output. A pressed flag stays high while scans keep finding a key. The flag drops at the end of any full four-column sweep that found nothing. The scan rate is set by a parameter, so that the keypad is never polled faster than it can settle.

Top module: `kpd_scan_top`

## Requirements
- R1: While reset is asserted and after it is released, the column drive `col_no` is 4'b1110, `pressed_o` is 0 and `key_o` is 0.
- R2: Exactly one bit of `col_no` is low at every clock edge outside reset.
- R3: The low column moves once every `TICK_DIV` clock cycles. The first move comes `TICK_DIV` cycles after reset release. The drive repeats the order 1110, 1101, 1011, 0111, and the column is stable between moves.
- R4: Pulling bit r of `row_ni` low while bit c of `col_no` is low (r, c in 0..3) selects the key at row r, column c. The layout by row is: row 0 = 1,2,3,A; row 1 = 4,5,6,B; row 2 = 7,8,9,C; row 3 = 0,F,E,D.
- R5: When a scan step sees exactly one low row, `key_o` takes the hex value of that key and `pressed_o` goes high. Both change only on a scan step.
- R6: While a key stays held, `pressed_o` stays high. After a full sweep of all four columns finds no key, `pressed_o` falls at the step on column 0111, and `key_o` keeps the last digit.
- R7: A scan step that sees two or more low rows in the driven column counts as no key. It does not change `key_o`, and a full sweep of such steps clears `pressed_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_ni | input | 4 | Row sense lines, active low, pulled up |
| col_no | output | 4 | Column drive, exactly one bit low |
| key_o | output | 4 | Last decoded hex digit |
| pressed_o | output | 1 | High while a key is being found |

## Verification
The keypad is modelled in the bench as a switch matrix. A row line reads low only when a held key sits in the column being driven low, so the decode is exercised through real scanning rather than by forcing codes. Each of the 16 keys is pressed alone to tell apart the row order, the column order and the layout of the table. Releasing a key checks the flag timing and that the digit is held. A pair of keys in one column separates single-hot row codes from invalid ones. A key held over several sweeps shows that the flag does not drop between hits.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  typedef struct packed {
    logic       hit;
    logic [3:0] digit;
  } kpd_entry_t;

  // layout index = row*4 + col
  function automatic logic [3:0] kpd_key_at(input logic [3:0] idx);
    logic [3:0] d;
    case (idx)
      4'd0:  d = 4'h1;
      4'd1:  d = 4'h2;
      4'd2:  d = 4'h3;
      4'd3:  d = 4'hA;
      4'd4:  d = 4'h4;
      4'd5:  d = 4'h5;
      4'd6:  d = 4'h6;
      4'd7:  d = 4'hB;
      4'd8:  d = 4'h7;
      4'd9:  d = 4'h8;
      4'd10: d = 4'h9;
      4'd11: d = 4'hC;
      4'd12: d = 4'h0;
      4'd13: d = 4'hF;
      4'd14: d = 4'hE;
      default: d = 4'hD;
    endcase
    return d;
  endfunction

  function automatic kpd_entry_t kpd_map(input logic [7:0] code);
    kpd_entry_t e;
    logic [3:0] r_oh;
    logic [3:0] c_oh;
    int r;
    int c;
    r_oh = code[7:4];
    c_oh = code[3:0];
    e = '0;
    r = 0;
    c = 0;
    for (int k = 0; k < 4; k++) begin
      if (r_oh[k]) r = k;
      if (c_oh[k]) c = k;
    end
    if ($countones(r_oh) == 1 && $countones(c_oh) == 1) begin
      e.hit   = 1'b1;
      e.digit = kpd_key_at(4'(r * 4 + c));
    end
    return e;
  endfunction

endpackage

// File: rtl/kpd_tick_div.sv
module kpd_tick_div #(
  parameter int TICK_DIV = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/kpd_col_ring.sv
module kpd_col_ring #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [WIDTH-1:0] col_no,
  output logic             last_o
);
  localparam logic [WIDTH-1:0] INIT = {{(WIDTH-1){1'b1}}, 1'b0};

  logic [WIDTH-1:0] ring_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ring_q <= INIT;
    else if (step_i) ring_q <= {ring_q[WIDTH-2:0], ring_q[WIDTH-1]};
  end

  assign col_no = ring_q;
  assign last_o = ~ring_q[WIDTH-1];
endmodule

// File: rtl/kpd_decode_lut.sv
module kpd_decode_lut
  import kpd_pkg::*;
(
  input  logic [7:0] code_i,
  output kpd_entry_t ent_o
);
  localparam int DEPTH = 256;

  kpd_entry_t tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign tbl[g] = kpd_map(8'(g));
  end

  assign ent_o = tbl[code_i];
endmodule

// File: rtl/kpd_scan_top.sv
module kpd_scan_top
  import kpd_pkg::*;
#(
  parameter int TICK_DIV = 3000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] row_ni,
  output logic [3:0] col_no,
  output logic [3:0] key_o,
  output logic       pressed_o
);
  logic       tick_w;
  logic       last_col_w;
  logic [7:0] code_w;
  kpd_entry_t ent_w;
  logic       seen_q;

  kpd_tick_div #(.TICK_DIV(TICK_DIV)) div_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick_w)
  );

  kpd_col_ring #(.WIDTH(4)) ring_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (tick_w),
    .col_no (col_no),
    .last_o (last_col_w)
  );

  assign code_w = {~row_ni, ~col_no};

  kpd_decode_lut lut_i (
    .code_i (code_w),
    .ent_o  (ent_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_o     <= '0;
      pressed_o <= 1'b0;
      seen_q    <= 1'b0;
    end else if (tick_w) begin
      if (ent_w.hit) begin
        key_o     <= ent_w.digit;
        pressed_o <= 1'b1;
      end
      if (last_col_w) begin
        seen_q <= 1'b0;
        if (!seen_q && !ent_w.hit) pressed_o <= 1'b0;
      end else if (ent_w.hit) begin
        seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/kpd_scan_chk.sv
module kpd_scan_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] col_i,
  input logic [3:0] key_i,
  input logic       pressed_i,
  input logic       tick_i,
  input logic       last_col_i
);
  AST_ONE_COL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~col_i) == 1); // R2

  AST_COL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(col_i)); // R3

  AST_COL_ROTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (col_i == {$past(col_i[2:0]), $past(col_i[3])})); // R3

  AST_KEY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(key_i) |-> $past(tick_i)); // R5

  AST_PRESS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pressed_i) |-> $past(tick_i)); // R5

  AST_RELEASE_AT_SWEEP_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pressed_i) |-> $past(tick_i && last_col_i)); // R6
endmodule

bind kpd_scan_top kpd_scan_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .col_i      (col_no),
  .key_i      (key_o),
  .pressed_i  (pressed_o),
  .tick_i     (tick_w),
  .last_col_i (last_col_w)
);

// File: tb/kpd_scan_top_tb.sv
module kpd_scan_top_tb_top;
  localparam int TD    = 4;
  localparam int SWEEP = 4 * TD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] row_n;
  logic [3:0] col_n;
  logic [3:0] key;
  logic       pressed;
  logic [15:0] held = '0;  // bit r*4+c
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  kpd_scan_top #(.TICK_DIV(TD)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .row_ni    (row_n),
    .col_no    (col_n),
    .key_o     (key),
    .pressed_o (pressed)
  );

  // switch matrix model
  always_comb begin
    for (int r = 0; r < 4; r++) begin
      row_n[r] = 1'b1;
      for (int c = 0; c < 4; c++)
        if (held[r*4+c] && !col_n[c]) row_n[r] = 1'b0;
    end
  end

  function automatic logic [3:0] exp_digit(input int idx);
    logic [3:0] t [16] = '{4'h1, 4'h2, 4'h3, 4'hA, 4'h4, 4'h5, 4'h6, 4'hB,
                           4'h7, 4'h8, 4'h9, 4'hC, 4'h0, 4'hF, 4'hE, 4'hD};
    return t[idx];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    held  = '0;
    wait_cycles(3);
    chk(col_n == 4'b1110, "R1", "col in reset", col_n, 4'b1110);
    chk(pressed == 1'b0, "R1", "pressed in reset", pressed, 0);
    chk(key == 4'h0, "R1", "key in reset", key, 0);
    rst_n = 1'b1;
    wait_cycles(1);
    chk(col_n == 4'b1110, "R1", "col after release", col_n, 4'b1110);
  endtask

  task automatic t_col_sequence;
    logic [3:0] exp_seq [4] = '{4'b1101, 4'b1011, 4'b0111, 4'b1110};
    logic [3:0] prev;
    int n;
    rst_n = 1'b0;
    wait_cycles(2);
    rst_n = 1'b1;
    prev = col_n;
    for (int s = 0; s < 8; s++) begin
      n = 0;
      while (col_n == prev && n < 10 * TD) begin
        wait_cycles(1);
        n++;
      end
      chk(n == TD, "R3", "cycles per column step", n, TD);
      chk(col_n == exp_seq[s % 4], "R3", "column order", col_n, exp_seq[s % 4]);
      chk($countones(~col_n) == 1, "R2", "one column low", col_n, 0);
      prev = col_n;
    end
  endtask

  task automatic t_each_key;
    for (int k = 0; k < 16; k++) begin
      held = 16'(1) << k;
      wait_cycles(2 * SWEEP);
      chk(pressed == 1'b1, "R5", "pressed on key", pressed, 1);
      chk(key == exp_digit(k), "R4", "digit for row/col", key, exp_digit(k));
    end
  endtask

  task automatic t_hold;
    bit dropped = 1'b0;
    held = 16'(1) << 9;  // row 2, col 1 -> 8
    wait_cycles(SWEEP);
    for (int i = 0; i < 3 * SWEEP; i++) begin
      wait_cycles(1);
      if (!pressed) dropped = 1'b1;
    end
    chk(!dropped, "R6", "flag stays while held", dropped, 0);
    chk(key == 4'h8, "R4", "held key digit", key, 4'h8);
  endtask

  task automatic t_release;
    held = 16'(1) << 3;  // row 0, col 3 -> A
    wait_cycles(2 * SWEEP);
    chk(key == 4'hA, "R4", "key before release", key, 4'hA);
    held = '0;
    wait_cycles(2 * SWEEP + 1);
    chk(pressed == 1'b0, "R6", "flag clears after empty sweep", pressed, 0);
    chk(key == 4'hA, "R6", "digit held after release", key, 4'hA);
  endtask

  task automatic t_two_rows;
    held = 16'(1) << 14;  // row 3, col 2 -> E
    wait_cycles(2 * SWEEP);
    chk(key == 4'hE, "R4", "key before double press", key, 4'hE);
    held = (16'(1) << 2) | (16'(1) << 6);  // rows 0 and 1 in col 2
    wait_cycles(2 * SWEEP + 1);
    chk(pressed == 1'b0, "R7", "double row treated as none", pressed, 0);
    chk(key == 4'hE, "R7", "digit unchanged by double row", key, 4'hE);
    held = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_col_sequence();
    t_each_key();
    t_hold();
    t_release();
    t_two_rows();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule